// File: doc/BRIEF.md
# 1-Wire Timed Bit Sequencer

This block is the self-timed engine of a 1-Wire bus master. A host-side controller hands it one operation at a time: a reset with presence and short detection, a single time slot, a byte written as eight slots, a byte read as eight slots, or a three-slot search step. The block then produces every low pulse on the open-drain line and samples the line at fixed instants, with no further help from the host. A busy flag covers the whole operation. When the operation ends, the results wait in registers: presence, short, single-bit result, triplet second bit, direction taken and the read-data byte.

Timing is counted in ticks of a quarter microsecond. A divider derives these ticks from the system clock, and it restarts on every accepted command, so each event falls on a fixed clock count after acceptance. There are two timing sets, standard and overdrive. Both are parameters, and a speed input chooses between them when the command is accepted. A synchronous device-reset input aborts any operation and clears all results.

Top module: `ow_bit_sequencer`

## Requirements
- R1: After `rst_n` low, and one cycle after `dev_rst` high, `busy`, `pull_low`, `presence`, `short_det`, `bit_res`, `trip_second`, `dir_taken` and `rd_data` are all 0. `dev_rst` aborts an operation in progress.
- R2: With D clocks per tick, `busy` is high for exactly L·D cycles after the accepting edge. L is (reset low + reset high) for a reset, one slot length for a single bit, eight for either byte operation and three for a triplet.
- R3: A reset drives `pull_low` for the reset-low time (2400 ticks standard, 288 overdrive), then releases the line for the reset-high time (2336 / 296).
- R4: In a reset, the line is sampled once at reset-low + 32 ticks (standard) or + 3 ticks (overdrive), and once more at reset-low + 280 ticks or + 30 ticks. A low at the first sample sets `short_det` and forces `presence` to 0. Otherwise `presence` is the inverse of the second sample.
- R5: Each slot lasts 277 ticks (standard) or 42 ticks (overdrive). A one or read slot drives the line low for 32 / 4 ticks. A zero slot drives it low for 256 / 30 ticks.
- R6: Command code 2 (single bit) sends bit 7 of `cmd_arg` as its slot value. It stores the level sampled at 56 / 6 ticks in `bit_res`, including when it sends 0.
- R7: Code 3 (write byte) sends `cmd_arg` least significant bit first.
- R8: Code 4 (read byte) issues eight one slots. Sample i becomes `rd_data[i]`. `rd_data` changes only during a read byte or a device reset.
- R9: Code 5 (triplet) runs two read slots and then one write slot. `bit_res` and `trip_second` hold the two samples. The written bit is 1 if the first sample is 1, 0 if the samples are 0 then 1, and `cmd_arg[7]` if both are 0. `dir_taken` holds the written bit.
- R10: Code 1 is a reset. `ovd_sel` is sampled when the command is accepted: 1 selects overdrive timing for the whole operation, and later changes have no effect on it.
- R11: A command presented while `busy` is high, or carrying code 0, 6 or 7, is ignored.
- R12: `bit_res` changes only in single-bit and triplet operations. `trip_second` and `dir_taken` change only in triplets. `presence` and `short_det` change only in resets. `dev_rst` is the exception and clears all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_rst | input | 1 | Synchronous device reset; aborts and clears |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 3 | Command code (1 reset, 2 bit, 3 write byte, 4 read byte, 5 triplet) |
| cmd_arg | input | 8 | Command parameter byte |
| ovd_sel | input | 1 | Speed for the next command: 1 overdrive |
| line_in | input | 1 | Sensed level of the 1-Wire line |
| pull_low | output | 1 | Open-drain pulldown enable |
| busy | output | 1 | Operation in progress |
| presence | output | 1 | Presence detected in the last reset |
| short_det | output | 1 | Short detected in the last reset |
| bit_res | output | 1 | Single-bit result or first triplet sample |
| trip_second | output | 1 | Second triplet sample |
| dir_taken | output | 1 | Bit written in the last triplet |
| rd_data | output | 8 | Byte assembled by the last read byte |

## Verification
Every event is a fixed number of clocks after the accepting edge. The k-th tick lands k·D clocks later. A sample taken at tick m updates its result register on that edge. `busy` falls exactly L·D clocks after acceptance. The bench drives inputs and samples outputs on falling edges. It counts the falling edges that see `busy` high and compares the total with L·D. It reads the results on the first falling edge that sees `busy` low, by which time every sample of the operation has been taken. A bus-slave model in the bench measures each low pulse in clocks and compares it with the tick count times D. The model answers by holding the line low from the start of a slot until three ticks past the sample point, so the line is stable whenever it is sampled.

// File: rtl/owseq_pkg.sv
package owseq_pkg;
   localparam int TW = 16;

   typedef enum logic [2:0] {
      OP_NONE  = 3'd0,
      OP_RESET = 3'd1,
      OP_BIT   = 3'd2,
      OP_WBYTE = 3'd3,
      OP_RBYTE = 3'd4,
      OP_TRIP  = 3'd5
   } op_e;

   // one timing set, all values in ticks, sample points measured from phase start
   typedef struct packed {
      logic [TW-1:0] rst_lo;
      logic [TW-1:0] rst_len;
      logic [TW-1:0] at_short;
      logic [TW-1:0] at_pres;
      logic [TW-1:0] slot_len;
      logic [TW-1:0] lo_one;
      logic [TW-1:0] lo_zero;
      logic [TW-1:0] at_samp;
   } tim_t;
endpackage

// File: rtl/owseq_tick_gen.sv
module owseq_tick_gen #(
   parameter int DIV = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_pass
         assign tick = 1'b1;
      end else begin : g_div
         localparam int DW = $clog2(DIV);
         logic [DW-1:0] div_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              div_q <= '0;
            else if (clr || div_q == DW'(DIV - 1))   div_q <= '0;
            else                                     div_q <= div_q + 1'b1;
         end
         assign tick = !clr && (div_q == DW'(DIV - 1));
      end
   endgenerate
endmodule

// File: rtl/owseq_phase_timer.sv
module owseq_phase_timer #(
   parameter int TW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          halt,
   input  logic          run,
   input  logic          tick,
   input  logic [TW-1:0] len,
   output logic [TW-1:0] cnt,
   output logic          phase_end
);
   assign phase_end = run && tick && (cnt == len - TW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               cnt <= '0;
      else if (start || halt)   cnt <= '0;
      else if (run && tick)     cnt <= phase_end ? '0 : cnt + TW'(1);
   end
endmodule

// File: rtl/owseq_ctrl.sv
module owseq_ctrl
   import owseq_pkg::*;
(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dev_rst,
   input  logic          cmd_valid,
   input  logic [2:0]    cmd_op,
   input  logic [7:0]    cmd_arg,
   input  logic          ovd_sel,
   input  logic          line_in,
   input  logic          tick,
   input  logic [TW-1:0] cnt,
   input  logic          phase_end,
   input  tim_t          tim,
   output logic          start,
   output logic          spd_q,
   output logic [TW-1:0] len,
   output logic          busy,
   output logic          pull_low,
   output logic          presence,
   output logic          short_det,
   output logic          bit_res,
   output logic          trip_second,
   output logic          dir_taken,
   output logic [7:0]    rd_data
);
   op_e           op_q;
   logic          is_rst;
   logic [2:0]    slot_idx, last_idx;
   logic          cur_bit, dir_in;
   logic [7:0]    wsh;
   logic [TW-1:0] lo_len;
   logic          op_ok, s_slot, s_short, s_pres, tdir;

   assign op_ok  = cmd_op inside {OP_RESET, OP_BIT, OP_WBYTE, OP_RBYTE, OP_TRIP};
   assign start  = cmd_valid && op_ok && !busy && !dev_rst;
   assign len    = is_rst ? tim.rst_len : tim.slot_len;
   assign lo_len = is_rst ? tim.rst_lo : (cur_bit ? tim.lo_one : tim.lo_zero);
   assign pull_low = busy && (cnt < lo_len);

   assign s_slot  = busy && tick && !is_rst && (cnt == tim.at_samp  - TW'(1));
   assign s_short = busy && tick &&  is_rst && (cnt == tim.at_short - TW'(1));
   assign s_pres  = busy && tick &&  is_rst && (cnt == tim.at_pres  - TW'(1));

   // search decision: a 1 seen first wins, 0-then-1 forces 0, 0-0 follows the host
   assign tdir = bit_res ? 1'b1 : (trip_second ? 1'b0 : dir_in);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n || dev_rst) begin
         busy <= 1'b0;  op_q <= OP_NONE;  is_rst <= 1'b0;  spd_q <= 1'b0;
         slot_idx <= '0;  last_idx <= '0;  cur_bit <= 1'b1;  dir_in <= 1'b0;
         wsh <= '0;  presence <= 1'b0;  short_det <= 1'b0;  bit_res <= 1'b0;
         trip_second <= 1'b0;  dir_taken <= 1'b0;  rd_data <= '0;
      end else begin
         if (start) begin
            busy     <= 1'b1;
            op_q     <= op_e'(cmd_op);
            spd_q    <= ovd_sel;
            is_rst   <= (cmd_op == OP_RESET);
            slot_idx <= '0;
            dir_in   <= cmd_arg[7];
            wsh      <= cmd_arg;
            case (cmd_op)
               OP_BIT:   begin cur_bit <= cmd_arg[7]; last_idx <= 3'd0; end
               OP_WBYTE: begin cur_bit <= cmd_arg[0]; last_idx <= 3'd7; end
               OP_RBYTE: begin cur_bit <= 1'b1;       last_idx <= 3'd7; end
               OP_TRIP:  begin cur_bit <= 1'b1;       last_idx <= 3'd2; end
               default:  begin cur_bit <= 1'b1;       last_idx <= 3'd0; end
            endcase
         end
         if (s_short) begin
            short_det <= !line_in;
            if (!line_in) presence <= 1'b0;
         end
         if (s_pres) presence <= !line_in && !short_det;
         if (s_slot) begin
            case (op_q)
               OP_BIT:   bit_res <= line_in;
               OP_RBYTE: rd_data <= {line_in, rd_data[7:1]};
               OP_TRIP: begin
                  if (slot_idx == 3'd0)      bit_res     <= line_in;
                  else if (slot_idx == 3'd1) trip_second <= line_in;
               end
               default: ;
            endcase
         end
         if (phase_end) begin
            if (slot_idx == last_idx) begin
               busy <= 1'b0;
            end else begin
               slot_idx <= slot_idx + 3'd1;
               if (op_q == OP_WBYTE) begin
                  wsh     <= {1'b0, wsh[7:1]};
                  cur_bit <= wsh[1];
               end else if (op_q == OP_TRIP && slot_idx == 3'd1) begin
                  cur_bit   <= tdir;
                  dir_taken <= tdir;
               end
            end
         end
      end
   end
endmodule

// File: rtl/ow_bit_sequencer.sv
module ow_bit_sequencer
   import owseq_pkg::*;
#(
   parameter int CLK_PER_TICK = 12,
   parameter int STD_RST_LO   = 2400,
   parameter int STD_RST_HI   = 2336,
   parameter int STD_SHORT_AT = 32,
   parameter int STD_PRES_AT  = 280,
   parameter int STD_SLOT     = 277,
   parameter int STD_LO_ONE   = 32,
   parameter int STD_LO_ZERO  = 256,
   parameter int STD_SAMP_AT  = 56,
   parameter int OVD_RST_LO   = 288,
   parameter int OVD_RST_HI   = 296,
   parameter int OVD_SHORT_AT = 3,
   parameter int OVD_PRES_AT  = 30,
   parameter int OVD_SLOT     = 42,
   parameter int OVD_LO_ONE   = 4,
   parameter int OVD_LO_ZERO  = 30,
   parameter int OVD_SAMP_AT  = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       dev_rst,
   input  logic       cmd_valid,
   input  logic [2:0] cmd_op,
   input  logic [7:0] cmd_arg,
   input  logic       ovd_sel,
   input  logic       line_in,
   output logic       pull_low,
   output logic       busy,
   output logic       presence,
   output logic       short_det,
   output logic       bit_res,
   output logic       trip_second,
   output logic       dir_taken,
   output logic [7:0] rd_data
);
   localparam int TMAX = (1 << TW) - 1;

   localparam tim_t TIM_STD = '{
      rst_lo:   TW'(STD_RST_LO),
      rst_len:  TW'(STD_RST_LO + STD_RST_HI),
      at_short: TW'(STD_RST_LO + STD_SHORT_AT),
      at_pres:  TW'(STD_RST_LO + STD_PRES_AT),
      slot_len: TW'(STD_SLOT),
      lo_one:   TW'(STD_LO_ONE),
      lo_zero:  TW'(STD_LO_ZERO),
      at_samp:  TW'(STD_SAMP_AT)};
   localparam tim_t TIM_OVD = '{
      rst_lo:   TW'(OVD_RST_LO),
      rst_len:  TW'(OVD_RST_LO + OVD_RST_HI),
      at_short: TW'(OVD_RST_LO + OVD_SHORT_AT),
      at_pres:  TW'(OVD_RST_LO + OVD_PRES_AT),
      slot_len: TW'(OVD_SLOT),
      lo_one:   TW'(OVD_LO_ONE),
      lo_zero:  TW'(OVD_LO_ZERO),
      at_samp:  TW'(OVD_SAMP_AT)};

   generate
      if (CLK_PER_TICK < 1) begin : g_bad_div
         $error("CLK_PER_TICK must be at least 1");
      end
      if (STD_RST_LO + STD_RST_HI > TMAX || OVD_RST_LO + OVD_RST_HI > TMAX) begin : g_bad_w
         $error("reset phase does not fit the tick counter");
      end
      if (!(STD_LO_ONE < STD_SAMP_AT && STD_SAMP_AT < STD_SLOT && STD_LO_ZERO < STD_SLOT)) begin : g_bad_std
         $error("standard slot timing out of order");
      end
      if (!(OVD_LO_ONE < OVD_SAMP_AT && OVD_SAMP_AT < OVD_SLOT && OVD_LO_ZERO < OVD_SLOT)) begin : g_bad_ovd
         $error("overdrive slot timing out of order");
      end
      if (!(0 < STD_SHORT_AT && STD_SHORT_AT < STD_PRES_AT && STD_PRES_AT < STD_RST_HI &&
            0 < OVD_SHORT_AT && OVD_SHORT_AT < OVD_PRES_AT && OVD_PRES_AT < OVD_RST_HI)) begin : g_bad_rst
         $error("reset sample points out of order");
      end
   endgenerate

   logic          tick, start, spd_q, phase_end;
   logic [TW-1:0] cnt, len;
   tim_t          tim_sel;

   assign tim_sel = spd_q ? TIM_OVD : TIM_STD;

   owseq_tick_gen #(.DIV(CLK_PER_TICK)) tick_i (
      .clk(clk), .rst_n(rst_n), .clr(start), .tick(tick));

   owseq_phase_timer #(.TW(TW)) timer_i (
      .clk(clk), .rst_n(rst_n), .start(start), .halt(dev_rst), .run(busy),
      .tick(tick), .len(len), .cnt(cnt), .phase_end(phase_end));

   owseq_ctrl ctrl_i (
      .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_arg(cmd_arg), .ovd_sel(ovd_sel), .line_in(line_in),
      .tick(tick), .cnt(cnt), .phase_end(phase_end), .tim(tim_sel),
      .start(start), .spd_q(spd_q), .len(len), .busy(busy), .pull_low(pull_low),
      .presence(presence), .short_det(short_det), .bit_res(bit_res),
      .trip_second(trip_second), .dir_taken(dir_taken), .rd_data(rd_data));
endmodule

// File: rtl/owseq_chk.sv
module owseq_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       dev_rst,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic       busy,
   input logic       pull_low,
   input logic       presence,
   input logic       short_det,
   input logic [7:0] rd_data
);
   // R11
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(cmd_valid) && ($past(cmd_op) != 3'd0));

   // R1
   abort_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dev_rst |=> !busy && !pull_low && !presence && !short_det && (rd_data == 8'h00));

   // R4
   short_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      short_det |-> !presence);

   // R5
   idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !pull_low);

   // R8
   rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !dev_rst) |=> $stable(rd_data));
endmodule

bind ow_bit_sequencer owseq_chk chk_i (
   .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .cmd_valid(cmd_valid),
   .cmd_op(cmd_op), .busy(busy), .pull_low(pull_low), .presence(presence),
   .short_det(short_det), .rd_data(rd_data));

// File: tb/ow_bit_sequencer_tb_top.sv
module ow_bit_sequencer_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int D = 2;
   // own copy of the timing sets, in ticks
   localparam int S_RLO = 2400, S_RHI = 2336, S_SI = 32, S_MSP = 280, S_SLOT = 277, S_L1 = 32, S_L0 = 256, S_MSR = 56;
   localparam int O_RLO = 288,  O_RHI = 296,  O_SI = 3,  O_MSP = 30,  O_SLOT = 42,  O_L1 = 4,  O_L0 = 30,  O_MSR = 6;
   localparam logic [2:0] C_RST = 3'd1, C_BIT = 3'd2, C_WB = 3'd3, C_RB = 3'd4, C_TRI = 3'd5;

   typedef struct packed {
      logic [2:0] op;   logic [7:0] arg;  logic ovd;  logic [1:0] rmode;
      logic [7:0] resp; logic [7:0] wbits; logic [7:0] rd;
      logic sbr; logic tsb; logic dir; logic ppd; logic sd;
   } vec_t;

   // rmode: 0 silent, 1 presence, 2 shorted; resp bit i: slave answer in slot i
   localparam vec_t VT [13] = '{
      '{C_RST, 8'h00, 1'b0, 2'd1, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      '{C_BIT, 8'h80, 1'b0, 2'd0, 8'hFF, 8'h01, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      '{C_WB,  8'h26, 1'b0, 2'd0, 8'hFF, 8'h26, 8'h00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      '{C_RB,  8'h00, 1'b1, 2'd0, 8'h5C, 8'hFF, 8'h5C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
      '{C_BIT, 8'h00, 1'b0, 2'd0, 8'hFF, 8'h00, 8'h5C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      '{C_TRI, 8'h80, 1'b0, 2'd0, 8'hFC, 8'h07, 8'h5C, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
      '{C_TRI, 8'h80, 1'b1, 2'd0, 8'hFE, 8'h03, 8'h5C, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0},
      '{C_TRI, 8'h00, 1'b0, 2'd0, 8'hFD, 8'h07, 8'h5C, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},
      '{C_TRI, 8'h00, 1'b1, 2'd0, 8'hFF, 8'h07, 8'h5C, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
      '{C_TRI, 8'h00, 1'b0, 2'd0, 8'hFC, 8'h03, 8'h5C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
      '{C_RST, 8'h00, 1'b1, 2'd2, 8'hFF, 8'hFF, 8'h5C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
      '{C_RST, 8'h00, 1'b0, 2'd0, 8'hFF, 8'hFF, 8'h5C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
      '{C_RST, 8'h00, 1'b1, 2'd1, 8'hFF, 8'hFF, 8'h5C, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0}
   };

   logic clk = 1'b0, rst_n = 1'b0, dev_rst = 1'b0, cmd_valid = 1'b0, ovd_sel = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_arg = 8'h00;
   logic pull_low, busy, presence, short_det, bit_res, trip_second, dir_taken, line_in;
   logic [7:0] rd_data;
   logic slave_low = 1'b0;

   int n_chk = 0, n_fail = 0;
   int since = 0, lowcnt = 0, slot_i = -1, log_n = 0;
   int lowlog [8];
   logic prev_pl = 1'b0, cur_ovd = 1'b0;
   logic [2:0] cur_op = 3'd0;
   logic [1:0] cur_rmode = 2'd0;
   logic [7:0] cur_resp = 8'hFF;

   always #(CLK_PERIOD/2) clk = ~clk;
   assign line_in = !(pull_low || slave_low);

   ow_bit_sequencer #(.CLK_PER_TICK(D)) dut_i (
      .clk(clk), .rst_n(rst_n), .dev_rst(dev_rst), .cmd_valid(cmd_valid),
      .cmd_op(cmd_op), .cmd_arg(cmd_arg), .ovd_sel(ovd_sel), .line_in(line_in),
      .pull_low(pull_low), .busy(busy), .presence(presence), .short_det(short_det),
      .bit_res(bit_res), .trip_second(trip_second), .dir_taken(dir_taken), .rd_data(rd_data));

   // bus slave model and low-pulse logger
   always @(negedge clk) begin
      int rlo, si, msp, msr;
      rlo = cur_ovd ? O_RLO : S_RLO;  si  = cur_ovd ? O_SI  : S_SI;
      msp = cur_ovd ? O_MSP : S_MSP;  msr = cur_ovd ? O_MSR : S_MSR;
      if (pull_low && !prev_pl) begin since = 0; slot_i++; end
      else since++;
      if (pull_low) lowcnt++;
      else if (prev_pl) begin
         if (log_n < 8) lowlog[log_n] = lowcnt;
         log_n++;
         lowcnt = 0;
      end
      prev_pl = pull_low;
      if (cur_op == C_RST) begin
         if (cur_rmode == 2'd2)      slave_low = busy;
         else if (cur_rmode == 2'd1) slave_low = busy && since >= (rlo + si + 2) * D && since < (rlo + msp + 8) * D;
         else                        slave_low = 1'b0;
      end else begin
         slave_low = busy && slot_i >= 0 && slot_i < 8 && !cur_resp[slot_i] && since < (msr + 3) * D;
      end
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] arg, input logic ovd,
                        input logic [1:0] rmode, input logic [7:0] resp);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_arg = arg; ovd_sel = ovd;
      cur_op = op; cur_ovd = ovd; cur_rmode = rmode; cur_resp = resp;
      slot_i = -1; log_n = 0; lowcnt = 0;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic wait_idle(inout int n);
      while (busy && n < 100000) begin n++; @(negedge clk); end
   endtask

   function automatic int op_len(input logic [2:0] op, input logic ovd);
      int sl = ovd ? O_SLOT : S_SLOT;
      case (op)
         C_RST:        return ovd ? (O_RLO + O_RHI) : (S_RLO + S_RHI);
         C_WB, C_RB:   return 8 * sl;
         C_TRI:        return 3 * sl;
         default:      return sl;
      endcase
   endfunction

   function automatic int op_slots(input logic [2:0] op);
      case (op)
         C_WB, C_RB: return 8;
         C_TRI:      return 3;
         default:    return 1;
      endcase
   endfunction

   task automatic check_status(input string req, input vec_t v);
      check(req, "bit_res", bit_res, v.sbr);
      check(req, "trip_second", trip_second, v.tsb);
      check(req, "dir_taken", dir_taken, v.dir);
      check(req, "presence", presence, v.ppd);
      check(req, "short_det", short_det, v.sd);
      check(req, "rd_data", rd_data, v.rd);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1", "busy after reset", busy, 0);
      check("R1", "pull_low after reset", pull_low, 0);
      check_status("R1", '{3'd0, 8'h00, 1'b0, 2'd0, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});

      // R11 code 0 ignored
      @(negedge clk); cmd_valid = 1'b1; cmd_op = 3'd0;
      @(negedge clk); cmd_valid = 1'b0;
      check("R11", "busy after code 0", busy, 0);
      check("R11", "pull_low after code 0", pull_low, 0);

      // table: R2..R10, R12 across operations and both speeds
      foreach (VT[i]) begin
         vec_t v = VT[i];
         string rq;
         rq = (v.op == C_RST) ? "R4" : (v.op == C_BIT) ? "R6" : (v.op == C_WB) ? "R7" :
              (v.op == C_RB) ? "R8" : "R9";
         issue(v.op, v.arg, v.ovd, v.rmode, v.resp);
         n = 0;
         wait_idle(n);
         check(v.ovd ? "R10" : "R2", "busy cycles", n, op_len(v.op, v.ovd) * D);
         check("R5", "low pulse count", log_n, op_slots(v.op));
         for (int k = 0; k < op_slots(v.op) && k < 8; k++) begin
            int exp;
            if (v.op == C_RST) exp = (v.ovd ? O_RLO : S_RLO) * D;
            else exp = (v.wbits[k] ? (v.ovd ? O_L1 : S_L1) : (v.ovd ? O_L0 : S_L0)) * D;
            check(v.op == C_RST ? "R3" : "R5", "low pulse length", lowlog[k], exp);
         end
         check_status(rq, v);
         check("R12", "untouched fields kept", {bit_res, trip_second, dir_taken, presence, short_det},
               {v.sbr, v.tsb, v.dir, v.ppd, v.sd});
      end

      // R11 command during busy ignored; read byte of all ones completes on time
      issue(C_RB, 8'h00, 1'b1, 2'd0, 8'hFF);
      n = 0;
      for (int k = 0; k < 10; k++) begin n++; @(negedge clk); end
      cmd_valid = 1'b1; cmd_op = C_RST;
      n++; @(negedge clk);
      cmd_valid = 1'b0;
      wait_idle(n);
      check("R11", "busy cycles with command in flight", n, 8 * O_SLOT * D);
      check("R11", "presence kept", presence, 1);
      check("R8", "rd_data all ones", rd_data, 8'hFF);

      // R10 speed latched at acceptance
      issue(C_BIT, 8'h80, 1'b0, 2'd0, 8'hFF);
      ovd_sel = 1'b1;
      n = 0;
      wait_idle(n);
      check("R10", "standard slot despite later speed change", n, S_SLOT * D);
      check("R10", "low length standard one", lowlog[0], S_L1 * D);

      // R1 abort by device reset
      issue(C_RST, 8'h00, 1'b0, 2'd1, 8'hFF);
      repeat (100) @(negedge clk);
      dev_rst = 1'b1;
      @(negedge clk);
      dev_rst = 1'b0;
      check("R1", "busy after abort", busy, 0);
      check("R1", "pull_low after abort", pull_low, 0);
      check_status("R1", '{3'd0, 8'h00, 1'b0, 2'd0, 8'hFF, 8'hFF, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
      repeat (5) @(negedge clk);
      check("R1", "stays idle after abort", busy, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule